// File: doc/BRIEF.md
# Half-Bridge Gate Command Guard

This block is the digital command path for one inverter leg. It accepts a high-side command (active high), a low-side command (active low), a stop input (active low), a supply-good qualifier and a high-side supply-good qualifier. From these it produces two gate enables, one for each switch of the leg. A command pair that would close both switches is decoded as "both off". Any turn-on is held back until a programmable dead window, counted in clock cycles, has run out since the last turn-off of either gate.

All five inputs may be asynchronous. Each passes through a synchroniser of `SYNC_STAGES` flops, then through a decode stage, and then into a registered dead-time stage. A turn-off therefore reaches the gate pin `SYNC_STAGES+1` clock edges after the input changes. A turn-on takes at least that long, and longer while the dead window is still open. The pins are plain level controls; no data streams through the block, so it has no valid/ready handshake. `DEAD_CYCLES` must be at least 1. At a 100 MHz clock, the default of 120 gives 1.2 µs.

Top module: `hb_gate_guard`

## Requirements
- R1: While the stop input `stop_n_i` is 0, both gate outputs are 0, whatever the other inputs are. Both gates reach 0 no later than `SYNC_STAGES+1` edges after `stop_n_i` falls.
- R2: The high command `hi_cmd_i` is active at 1 and the low command `lo_cmd_n_i` is active at 0. With only the high command active, `hi_gate_o`=1 and `lo_gate_o`=0. With only the low command active, `lo_gate_o`=1 and `hi_gate_o`=0. Both cases apply once the dead window is closed.
- R3: When `hi_cmd_i`=1 and `lo_cmd_n_i`=0 at the same time, both gate outputs are 0.
- R4: When `hi_cmd_i`=0 and `lo_cmd_n_i`=1, both gate outputs are 0.
- R5: After either gate falls, no gate rises until both gates have been 0 for `DEAD_CYCLES+1` consecutive cycles. The counter restarts on every turn-off.
- R6: When the commands swap on the same edge, or the new command arrives while the dead window is open, both gates stay 0. The new gate rises on the first edge after the window expires, which is `DEAD_CYCLES+1` edges after the other gate fell.
- R7: While `supply_ok_i` is 0, both gate outputs are 0.
- R8: While `hs_supply_ok_i` is 0, `hi_gate_o` is 0. The low gate still follows the low command.
- R9: During reset both gates are 0. Release from reset opens a dead window, so the first turn-on happens no earlier than `DEAD_CYCLES+1` edges after release.
- R10: `lo_gate_o` and `hi_gate_o` are never 1 at the same time.
- R11: A turn-off is not delayed by the dead window. A gate falls exactly `SYNC_STAGES+1` edges after its command goes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cmd_i | input | 1 | High-side switch command, active high, asynchronous |
| lo_cmd_n_i | input | 1 | Low-side switch command, active low, asynchronous |
| stop_n_i | input | 1 | Stop request, active low, forces both gates off |
| supply_ok_i | input | 1 | Supply-good qualifier; 0 forces both gates off |
| hs_supply_ok_i | input | 1 | High-side supply-good qualifier; 0 forces the high gate off |
| lo_gate_o | output | 1 | Low-side gate enable |
| hi_gate_o | output | 1 | High-side gate enable |

## Verification
The checker assumes the inputs reach the decode after exactly `SYNC_STAGES` flops. It therefore relates each gate to copies of the inputs delayed by `SYNC_STAGES+1` cycles, and it assumes reset is held long enough for those delay lines to fill. The bench changes inputs only on the falling clock edge, so every change is sampled cleanly and the latency stays fixed. Random hold lengths range from one cycle to three dead windows. This mix puts many command changes inside an open window, while others arrive after the window has closed.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic [1:0] {
    LEG_IDLE = 2'd0,
    LEG_LOW  = 2'd1,
    LEG_HIGH = 2'd2
  } leg_req_e;

  localparam int unsigned IN_W    = 5;
  localparam int unsigned B_HI    = 0;
  localparam int unsigned B_LON   = 1;
  localparam int unsigned B_STOPN = 2;
  localparam int unsigned B_SUP   = 3;
  localparam int unsigned B_HSUP  = 4;
  // safe values during reset: commands inactive, stop and supplies "bad"
  localparam logic [IN_W-1:0] IN_RST = 5'b00010;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hbg_decode.sv
module hbg_decode
  import hbg_pkg::*;
(
  input  logic [IN_W-1:0] in_i,
  output leg_req_e        req_o
);
  logic hi_act, lo_act;

  always_comb begin
    hi_act = in_i[B_HI];
    lo_act = !in_i[B_LON];
    req_o  = LEG_IDLE;
    if (!in_i[B_STOPN] || !in_i[B_SUP]) begin
      req_o = LEG_IDLE;            // forced off
    end else if (hi_act && lo_act) begin
      req_o = LEG_IDLE;            // interlock
    end else if (hi_act) begin
      req_o = in_i[B_HSUP] ? LEG_HIGH : LEG_IDLE;
    end else if (lo_act) begin
      req_o = LEG_LOW;
    end
  end
endmodule

// File: rtl/hbg_dead.sv
module hbg_dead
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYCLES = 120
) (
  input  logic     clk,
  input  logic     rst_n,
  input  leg_req_e req_i,
  output logic     lo_o,
  output logic     hi_o
);
  localparam int unsigned CNT_W = $clog2(DEAD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic lo_q, hi_q, lo_d, hi_d;
  logic lo_want, hi_want, win_closed, turn_off;

  always_comb begin
    lo_want    = (req_i == LEG_LOW);
    hi_want    = (req_i == LEG_HIGH);
    win_closed = (cnt_q == '0);
    turn_off   = (lo_q && !lo_want) || (hi_q && !hi_want);
    lo_d = lo_q ? lo_want : (lo_want && !hi_q && win_closed);
    hi_d = hi_q ? hi_want : (hi_want && !lo_q && win_closed);
    if (turn_off)        cnt_d = CNT_LOAD;
    else if (!win_closed) cnt_d = cnt_q - 1'b1;
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= 1'b0;
      hi_q  <= 1'b0;
      cnt_q <= CNT_LOAD;   // reset counts as a turn-off
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      cnt_q <= cnt_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/hb_gate_guard.sv
module hb_gate_guard
  import hbg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEAD_CYCLES = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_cmd_i,
  input  logic lo_cmd_n_i,
  input  logic stop_n_i,
  input  logic supply_ok_i,
  input  logic hs_supply_ok_i,
  output logic lo_gate_o,
  output logic hi_gate_o
);
  logic [IN_W-1:0] raw_in, sync_in;
  leg_req_e        leg_req;

  always_comb begin
    raw_in          = '0;
    raw_in[B_HI]    = hi_cmd_i;
    raw_in[B_LON]   = lo_cmd_n_i;
    raw_in[B_STOPN] = stop_n_i;
    raw_in[B_SUP]   = supply_ok_i;
    raw_in[B_HSUP]  = hs_supply_ok_i;
  end

  hbg_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_in)
  );

  hbg_decode u_decode (.in_i(sync_in), .req_o(leg_req));

  hbg_dead #(.DEAD_CYCLES(DEAD_CYCLES)) u_dead (
    .clk(clk), .rst_n(rst_n), .req_i(leg_req), .lo_o(lo_gate_o), .hi_o(hi_gate_o)
  );
endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEAD_CYCLES = 120
) (
  input logic clk,
  input logic rst_n,
  input logic hi_cmd_i,
  input logic lo_cmd_n_i,
  input logic stop_n_i,
  input logic supply_ok_i,
  input logic hs_supply_ok_i,
  input logic lo_gate_o,
  input logic hi_gate_o
);
  localparam int unsigned L  = SYNC_STAGES;
  localparam int unsigned QMAX = DEAD_CYCLES + 1;
  localparam int unsigned QW = $clog2(DEAD_CYCLES + 2);

  logic [L:0] dl_hi, dl_lon, dl_stop, dl_sup, dl_hs;
  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_hi <= '0; dl_lon <= '1; dl_stop <= '0; dl_sup <= '0; dl_hs <= '0;
      quiet_q <= '0;
    end else begin
      dl_hi   <= {dl_hi[L-1:0],   hi_cmd_i};
      dl_lon  <= {dl_lon[L-1:0],  lo_cmd_n_i};
      dl_stop <= {dl_stop[L-1:0], stop_n_i};
      dl_sup  <= {dl_sup[L-1:0],  supply_ok_i};
      dl_hs   <= {dl_hs[L-1:0],   hs_supply_ok_i};
      if (lo_gate_o || hi_gate_o)  quiet_q <= '0;
      else if (quiet_q != QW'(QMAX)) quiet_q <= quiet_q + 1'b1;
    end
  end

  assert_stop_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dl_stop[L] |-> (!lo_gate_o && !hi_gate_o));
  assert_interlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_hi[L] && !dl_lon[L]) |-> (!lo_gate_o && !hi_gate_o));
  assert_dead_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lo_gate_o) || $rose(hi_gate_o)) |-> (quiet_q >= QW'(QMAX)));
  assert_supply_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dl_sup[L] |-> (!lo_gate_o && !hi_gate_o));
  assert_hs_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dl_hs[L] |-> !hi_gate_o);
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lo_gate_o, hi_gate_o}) <= 1);
endmodule

bind hb_gate_guard hbg_checker #(.SYNC_STAGES(SYNC_STAGES), .DEAD_CYCLES(DEAD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .hi_cmd_i(hi_cmd_i), .lo_cmd_n_i(lo_cmd_n_i),
  .stop_n_i(stop_n_i), .supply_ok_i(supply_ok_i), .hs_supply_ok_i(hs_supply_ok_i),
  .lo_gate_o(lo_gate_o), .hi_gate_o(hi_gate_o)
);

// File: tb/hb_gate_guard_tb.sv
module hb_gate_guard_tb;
  localparam int D = 6;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi = 1'b0, lon = 1'b1, stp = 1'b0, sup = 1'b0, hs = 1'b0;
  logic lo_g, hi_g;
  int n_chk = 0, n_fail = 0;
  bit model_on = 1'b0;

  always #5 clk = ~clk;

  hb_gate_guard #(.SYNC_STAGES(S), .DEAD_CYCLES(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .hi_cmd_i(hi), .lo_cmd_n_i(lon), .stop_n_i(stp),
    .supply_ok_i(sup), .hs_supply_ok_i(hs), .lo_gate_o(lo_g), .hi_gate_o(hi_g)
  );

  // requirement-level reference: fixed input latency, then truth table and dead window
  function automatic int want_of(logic [4:0] v);
    if (!v[2] || !v[3]) return 0;
    if (v[0] && !v[1]) return 0;
    if (v[0]) return v[4] ? 2 : 0;
    if (!v[1]) return 1;
    return 0;
  endfunction

  function automatic string tag_of(logic [4:0] v);
    if (!v[2]) return "R1";
    if (!v[3]) return "R7";
    if (v[0] && !v[1]) return "R3";
    if (v[0] && !v[4]) return "R8";
    if (!v[0] && v[1]) return "R4";
    return "R2";
  endfunction

  logic [4:0] mq [S];
  logic m_lo, m_hi;
  int m_cnt;
  string m_tag = "R9";

  always @(posedge clk or negedge rst_n) begin : mdl
    int w;
    bit off, nlo, nhi;
    if (!rst_n) begin
      for (int i = 0; i < S; i++) mq[i] <= 5'b00010;
      m_lo <= 1'b0; m_hi <= 1'b0; m_cnt <= D; m_tag <= "R9";
    end else begin
      w   = want_of(mq[S-1]);
      off = (m_lo && w != 1) || (m_hi && w != 2);
      nlo = m_lo ? (w == 1) : (w == 1 && !m_hi && m_cnt == 0);
      nhi = m_hi ? (w == 2) : (w == 2 && !m_lo && m_cnt == 0);
      mq[0] <= {hs, sup, stp, lon, hi};
      for (int i = 1; i < S; i++) mq[i] <= mq[i-1];
      m_lo <= nlo; m_hi <= nhi;
      m_cnt <= off ? D : (m_cnt > 0 ? m_cnt - 1 : 0);
      m_tag <= ((w == 1 && !nlo) || (w == 2 && !nhi)) ? "R5" : tag_of(mq[S-1]);
    end
  end

  task automatic check(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, plus R10 exclusivity
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      check(m_tag, lo_g, m_lo, "lo_gate vs model");
      check(m_tag, hi_g, m_hi, "hi_gate vs model");
      check("R10", lo_g & hi_g, 1'b0, "both gates on");
    end
  end

  task automatic drive(logic h, logic ln, logic st, logic su, logic hh);
    hi = h; lon = ln; stp = st; sup = su; hs = hh;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    int i = 0;
    while (!done && i < 200000) begin @(posedge clk); i++; end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c3b_57a9));
    drive(0, 0, 1, 1, 1);            // low command pending through reset
    wait_n(3);
    check("R9", lo_g, 1'b0, "lo in reset");
    check("R9", hi_g, 1'b0, "hi in reset");
    rst_n = 1'b1;                    // released at a falling edge
    model_on = 1'b1;
    wait_n(D);
    check("R9", lo_g, 1'b0, "lo before window end");
    wait_n(1);
    check("R9", lo_g, 1'b1, "lo first turn-on");
    wait_n(5);

    // R11 / R6: swap on the same edge
    drive(1, 1, 1, 1, 1);
    wait_n(2);
    check("R11", lo_g, 1'b1, "lo before latency");
    wait_n(1);
    check("R11", lo_g, 1'b0, "lo off after S+1 edges");
    wait_n(D);
    check("R6", hi_g, 1'b0, "hi still in window");
    wait_n(1);
    check("R6", hi_g, 1'b1, "hi on at window end");
    wait_n(4);

    // R6: new command arrives inside the window
    drive(0, 1, 1, 1, 1);
    wait_n(5);
    drive(0, 0, 1, 1, 1);
    wait_n(D - 2);
    check("R6", lo_g, 1'b0, "lo held during window");
    wait_n(1);
    check("R6", lo_g, 1'b1, "lo on after window");
    wait_n(3);

    // R3 interlock, then R2 high alone
    drive(1, 0, 1, 1, 1);
    wait_n(3 * D);
    check("R3", lo_g, 1'b0, "lo under interlock");
    check("R3", hi_g, 1'b0, "hi under interlock");
    drive(1, 1, 1, 1, 1);
    wait_n(3 * D);
    check("R2", hi_g, 1'b1, "hi alone");
    check("R2", lo_g, 1'b0, "lo while hi alone");

    // R8 high-side supply bad
    drive(1, 1, 1, 1, 0);
    wait_n(3);
    check("R8", hi_g, 1'b0, "hi with hs supply bad");
    drive(0, 0, 1, 1, 0);
    wait_n(2 * D + 5);
    check("R8", lo_g, 1'b1, "lo unaffected by hs supply");

    // R1 stop
    drive(0, 0, 0, 1, 1);
    wait_n(2);
    check("R1", lo_g, 1'b1, "lo before stop latency");
    wait_n(1);
    check("R1", lo_g, 1'b0, "lo off by stop");
    drive(1, 1, 0, 1, 1);
    wait_n(3 * D);
    check("R1", hi_g, 1'b0, "hi held off by stop");

    // R7 supply bad
    drive(1, 1, 1, 0, 1);
    wait_n(3 * D);
    check("R7", hi_g, 1'b0, "hi with supply bad");
    check("R7", lo_g, 1'b0, "lo with supply bad");

    // R4 idle
    drive(0, 1, 1, 1, 1);
    wait_n(3 * D);
    check("R4", lo_g, 1'b0, "lo idle");
    check("R4", hi_g, 1'b0, "hi idle");

    // constrained random segments, checked every cycle by the model
    for (int seg = 0; seg < 600; seg++) begin
      drive(1'($urandom % 2), 1'($urandom % 2), ($urandom % 16) != 0,
            ($urandom % 20) != 0, ($urandom % 10) != 0);
      wait_n(1 + int'($urandom % (3 * D)));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule